// File: doc/BRIEF.md
# Parallel Flash Sector Erase Sequencer

This block sits on the host side of a byte-wide parallel flash and runs a complete sector erase without software stepping through it. A single start pulse hands it a count and a list of sector addresses. It writes the six-cycle unlock, set-up and erase command sequence for the first sector. While the device's sector-load window stays open, it adds each further sector with one more erase-confirm write. It then polls the device status until the erase completes, faults or runs out of time.

All device traffic goes through a simple synchronous bus master port. A request is held, with its address, direction and write data, until the target acknowledges it. Only one transaction is outstanding at a time. Completion is recognised by the toggle-stop rule on the status byte. A device fault or an expired poll budget makes the block write the device reset command, so the device is back in array-read mode when the block reports an error.

Top module: `efc_erase_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `error_o` and `bus_req_o` are all 0.
- R2: An accepted start moves `busy_o` to 1 at the next clock edge, and the first bus request follows one edge later. The first six transactions are writes of (address, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (first sector,0x30).
- R3: Before each further sector, the block reads status at the first sector address. If bit 3 is 0, it writes 0x30 to that sector's address. If bit 3 is 1, it appends nothing more, goes on polling, and reports `error_o`=1 at completion.
- R4: The block polls status reads at the first sector address. The erase counts as complete on a poll read with bit 7 = 1 whose bit 6 equals bit 6 of the previous poll read. The first poll read never completes. A completion with no other error gives `done_o` with `error_o`=0 and no further writes.
- R5: A non-completing poll read with bit 5 = 1 triggers exactly one more status read. If that read completes, the result is success. Otherwise the block writes 0xF0 to 0x555 and ends with `error_o`=1.
- R6: After MAX_POLLS poll reads without completion or fault, the block writes 0xF0 to 0x555 and ends with `error_o`=1.
- R7: A start pulse while `busy_o` is 1 is ignored. It causes no extra transactions and no extra `done_o`.
- R8: `done_o` is a one-cycle pulse, and `busy_o` is 0 on the following cycle. `error_o` is valid with `done_o` and holds until the next accepted start clears it.
- R9: A start with a count of 0 gives `done_o` with `error_o`=1 on the cycle after acceptance and makes no bus transaction. A count above MAX_SECT is treated as MAX_SECT.
- R10: While `bus_req_o` is 1 and `bus_ack_i` is 0, the request, address, direction and write data stay unchanged. `bus_req_o` falls on the edge that samples `bus_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| sect_cnt_i | input | CNT_W | Number of sectors to erase |
| sect_addr_i | input | MAX_SECT*ADDR_W | Sector addresses; entry i at bits [i*ADDR_W +: ADDR_W] |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| error_o | output | 1 | Operation failed or was incomplete |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge, one cycle |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |

## Verification
The reset state is sampled before the first start. After a start is driven, `busy_o` is checked one edge later and the first `bus_req_o` two edges later: one edge registers the sequencer state and one registers the request. A transaction's result reaches the sequencer one edge after its acknowledge. The bench therefore never predicts poll timing cycle by cycle. It waits for `done_o`, samples `error_o` at that same point, and then checks `busy_o` and a low `done_o` one edge later. The transaction log of the bench's flash model (sequence, sector order, reset write, poll-read count) is compared against values derived from the model's configured busy, fault and window read counts.

// File: rtl/efc_pkg.sv
package efc_pkg;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] CMD_UNLK1 = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_UNLK2 = 8'h55;
  localparam logic [DATA_W-1:0] CMD_SETUP = 8'h80;
  localparam logic [DATA_W-1:0] CMD_SECT  = 8'h30;
  localparam logic [DATA_W-1:0] CMD_RESET = 8'hF0;

  // status bit positions
  localparam int ST_DONE = 7;
  localparam int ST_TOG  = 6;
  localparam int ST_FAIL = 5;
  localparam int ST_WIN  = 3;

  localparam int ULK_STEPS = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_ULK, S_CHK, S_APP, S_POLL, S_RST, S_FIN
  } seq_state_e;
endpackage

// File: rtl/efc_bus_mst.sv
module efc_bus_mst
  import efc_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              cmd_done_o,
  output logic [DATA_W-1:0] cmd_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic              req_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_q) begin
        if (bus_ack_i) begin
          req_q   <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= bus_rdata_i;
        end
      end else if (cmd_valid_i && !done_q) begin
        req_q   <= 1'b1;
        we_q    <= cmd_we_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_data_i;
      end
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign cmd_done_o  = done_q;
  assign cmd_rdata_o = rdata_q;
endmodule

// File: rtl/efc_stat.sv
module efc_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic smp_i,
  input  logic done_bit_i,
  input  logic tog_bit_i,
  output logic comp_o
);
  logic prev_q, have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (smp_i) begin
      prev_q <= tog_bit_i;
      have_q <= 1'b1;
    end
  end

  // toggle stopped across two consecutive reads and done bit set
  assign comp_o = have_q && done_bit_i && (tog_bit_i == prev_q);
endmodule

// File: rtl/efc_wdog.sv
module efc_wdog #(
  parameter int MAX_POLLS = 4096,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !last_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/efc_seq.sv
module efc_seq
  import efc_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int MAX_SECT = 8,
  parameter int CNT_W    = 4,
  parameter logic [ADDR_W-1:0] UNLK_A1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLK_A2 = 'h2AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  sect_cnt_i,
  input  logic [ADDR_W-1:0] sect_addr_i [MAX_SECT],
  output logic              cmd_valid_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_done_i,
  input  logic              st_win_i,
  input  logic              st_fail_i,
  input  logic              stat_comp_i,
  output logic              stat_clr_o,
  output logic              stat_smp_o,
  output logic              wd_clr_o,
  output logic              wd_inc_o,
  input  logic              wd_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  seq_state_e        state_q;
  logic [2:0]        step_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic              pend_q, err_q, retry_q;
  logic [ADDR_W-1:0] sect_q [MAX_SECT];
  logic [ADDR_W-1:0] cur_sect;

  always_comb begin
    cur_sect = sect_q[0];
    for (int i = 0; i < MAX_SECT; i++)
      if (idx_q == CNT_W'(i)) cur_sect = sect_q[i];
  end

  always_comb begin
    cmd_valid_o = !pend_q && (state_q inside {S_ULK, S_CHK, S_APP, S_POLL, S_RST});
    cmd_we_o    = !(state_q inside {S_CHK, S_POLL});
    cmd_addr_o  = sect_q[0];
    cmd_data_o  = CMD_SECT;
    unique case (state_q)
      S_ULK: begin
        unique case (step_q)
          3'd0, 3'd3: begin cmd_addr_o = UNLK_A1; cmd_data_o = CMD_UNLK1; end
          3'd1, 3'd4: begin cmd_addr_o = UNLK_A2; cmd_data_o = CMD_UNLK2; end
          3'd2:       begin cmd_addr_o = UNLK_A1; cmd_data_o = CMD_SETUP; end
          default:    begin cmd_addr_o = sect_q[0]; cmd_data_o = CMD_SECT; end
        endcase
      end
      S_APP:   cmd_addr_o = cur_sect;
      S_RST:   begin cmd_addr_o = UNLK_A1; cmd_data_o = CMD_RESET; end
      default: ;
    endcase
  end

  assign stat_clr_o = (state_q != S_POLL);
  assign wd_clr_o   = (state_q != S_POLL);
  assign stat_smp_o = (state_q == S_POLL) && cmd_done_i;
  assign wd_inc_o   = (state_q == S_POLL) && cmd_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
      for (int i = 0; i < MAX_SECT; i++) sect_q[i] <= '0;
    end else begin
      if (cmd_valid_o)     pend_q <= 1'b1;
      else if (cmd_done_i) pend_q <= 1'b0;
      if (state_q != S_POLL) retry_q <= 1'b0;

      unique case (state_q)
        S_IDLE: if (start_i) begin
          err_q  <= 1'b0;
          step_q <= '0;
          cnt_q  <= (sect_cnt_i > CNT_W'(MAX_SECT)) ? CNT_W'(MAX_SECT) : sect_cnt_i;
          for (int i = 0; i < MAX_SECT; i++) sect_q[i] <= sect_addr_i[i];
          if (sect_cnt_i == '0) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            state_q <= S_ULK;
          end
        end
        S_ULK: if (cmd_done_i) begin
          if (step_q == 3'(ULK_STEPS - 1)) begin
            idx_q   <= CNT_W'(1);
            state_q <= (cnt_q > CNT_W'(1)) ? S_CHK : S_POLL;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        S_CHK: if (cmd_done_i) begin
          if (st_win_i) begin
            err_q   <= 1'b1;  // remaining sectors not loaded
            state_q <= S_POLL;
          end else begin
            state_q <= S_APP;
          end
        end
        S_APP: if (cmd_done_i) begin
          idx_q   <= idx_q + 1'b1;
          state_q <= (idx_q + 1'b1 < cnt_q) ? S_CHK : S_POLL;
        end
        S_POLL: if (cmd_done_i) begin
          if (stat_comp_i)    state_q <= S_FIN;
          else if (retry_q)   state_q <= S_RST;
          else if (st_fail_i) retry_q <= 1'b1;
          else if (wd_last_i) state_q <= S_RST;
        end
        S_RST: if (cmd_done_i) begin
          err_q   <= 1'b1;
          state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_FIN);
  assign error_o = err_q;
endmodule

// File: rtl/efc_erase_ctrl.sv
module efc_erase_ctrl
  import efc_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int MAX_SECT  = 8,
  parameter int MAX_POLLS = 4096,
  parameter logic [ADDR_W-1:0] UNLK_A1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLK_A2 = 'h2AA,
  localparam int CNT_W = $clog2(MAX_SECT + 1) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [CNT_W-1:0]           sect_cnt_i,
  input  logic [MAX_SECT*ADDR_W-1:0] sect_addr_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       error_o,
  output logic                       bus_req_o,
  output logic                       bus_we_o,
  output logic [ADDR_W-1:0]          bus_addr_o,
  output logic [7:0]                 bus_wdata_o,
  input  logic                       bus_ack_i,
  input  logic [7:0]                 bus_rdata_i
);
  logic [ADDR_W-1:0] sect_arr [MAX_SECT];
  logic              cmd_valid, cmd_we, cmd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data;
  logic              stat_clr, stat_smp, stat_comp;
  logic              wd_clr, wd_inc, wd_last;
  logic              unused_rd;

  for (genvar g = 0; g < MAX_SECT; g++) begin : g_sect
    assign sect_arr[g] = sect_addr_i[g*ADDR_W +: ADDR_W];
  end

  assign unused_rd = ^{rd_data[4], rd_data[2:0]};

  efc_seq #(
    .ADDR_W(ADDR_W), .MAX_SECT(MAX_SECT), .CNT_W(CNT_W),
    .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .sect_cnt_i, .sect_addr_i(sect_arr),
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cmd_done_i(cmd_done),
    .st_win_i(rd_data[ST_WIN]), .st_fail_i(rd_data[ST_FAIL]),
    .stat_comp_i(stat_comp), .stat_clr_o(stat_clr), .stat_smp_o(stat_smp),
    .wd_clr_o(wd_clr), .wd_inc_o(wd_inc), .wd_last_i(wd_last),
    .busy_o, .done_o, .error_o
  );

  efc_bus_mst #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .cmd_done_o(cmd_done), .cmd_rdata_o(rd_data),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_ack_i, .bus_rdata_i
  );

  efc_stat u_stat (
    .clk_i, .rst_ni,
    .clr_i(stat_clr), .smp_i(stat_smp),
    .done_bit_i(rd_data[ST_DONE]), .tog_bit_i(rd_data[ST_TOG]),
    .comp_o(stat_comp)
  );

  efc_wdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
    .clk_i, .rst_ni,
    .clr_i(wd_clr), .inc_i(wd_inc), .last_o(wd_last)
  );
endmodule

// File: rtl/efc_erase_ctrl_chk.sv
module efc_erase_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [7:0]        bus_wdata_o,
  input logic              bus_ack_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R10
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i) |=> !bus_req_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R8
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);
endmodule

bind efc_erase_ctrl efc_erase_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i)
);

// File: tb/sim_efc_erase_ctrl.sv
`timescale 1ns/1ps
module sim_efc_erase_ctrl;
  localparam int ADDR_W = 19;
  localparam int MAX_SECT = 4;
  localparam int MAX_POLLS = 24;
  localparam int CNT_W = $clog2(MAX_SECT + 1) + 1;

  // n_sect, busy_reads, win_after, fault_at, exp_err, exp_writes
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{1, 5, 9, 0, 0, 6},   // R4 single sector
    '{3, 9, 9, 0, 0, 8},   // R3 all appended
    '{4, 9, 1, 0, 1, 7},   // R3 window closes after one append
    '{2, 9, 9, 6, 1, 8},   // R5 fault while busy
    '{1, 7, 9, 7, 0, 6}    // R5 fault with completion on re-read
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [CNT_W-1:0] cnt = '0;
  logic [MAX_SECT*ADDR_W-1:0] sect_flat = '0;
  logic busy, done, err, req, we, ack = 0;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata = 8'hFF;

  always #5 clk = ~clk;

  efc_erase_ctrl #(.ADDR_W(ADDR_W), .MAX_SECT(MAX_SECT), .MAX_POLLS(MAX_POLLS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sect_cnt_i(cnt),
    .sect_addr_i(sect_flat), .busy_o(busy), .done_o(done), .error_o(err),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  int checks = 0, failures = 0;

  // flash model
  int cfg_busy = 0, cfg_win = 0, cfg_fault = 0;
  int rd_cnt = 0, rd_total = 0, wr_n = 0, rst_wr = 0;
  bit erasing = 0;
  int wr_a [64];
  int wr_d [64];

  always @(posedge clk) begin
    int rc;
    if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        if (wr_n < 64) begin wr_a[wr_n] = int'(addr); wr_d[wr_n] = int'(wdata); end
        wr_n = wr_n + 1;
        if (wdata == 8'h30 && !erasing) begin erasing = 1; rd_cnt = 0; end
        if (wdata == 8'hF0) begin erasing = 0; rst_wr = rst_wr + 1; end
      end else begin
        rd_total = rd_total + 1;
        if (erasing) begin
          rc = rd_cnt + 1;
          rd_cnt = rc;
          if (rc > cfg_busy) begin
            erasing = 0;
            rdata <= 8'hFF;
          end else begin
            rdata <= {1'b0, rc[0], (cfg_fault != 0 && rc >= cfg_fault), 1'b0,
                      (rc > cfg_win), 3'b000};
          end
        end else rdata <= 8'hFF;
      end
    end else ack <= 1'b0;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sect_of(input int i);
    return (i + 1) << 16;
  endfunction

  task automatic setup(input int n, input int b, input int w, input int f);
    cfg_busy = b; cfg_win = w; cfg_fault = f;
    wr_n = 0; rst_wr = 0; rd_total = 0;
    cnt = CNT_W'(n);
    for (int i = 0; i < MAX_SECT; i++) sect_flat[i*ADDR_W +: ADDR_W] = ADDR_W'(sect_of(i));
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  // wait for done; returns error sampled with done, or -1 on timeout
  task automatic wait_done(output int e);
    int t;
    t = 0;
    e = -1;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    if (done) e = int'(err);
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(err), 0);
    chk("R1 req", int'(req), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 timing of first request
    setup(1, 5, 9, 0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 req not yet", int'(req), 0);
    @(negedge clk);
    chk("R2 first req", int'(req), 1);
    wait_done(e);
    chk("R4 err", e, 0);
    chk("R2 writes", wr_n, 6);
    chk("R2 w0", wr_a[0] * 256 + wr_d[0], 'h555 * 256 + 'hAA);
    chk("R2 w1", wr_a[1] * 256 + wr_d[1], 'h2AA * 256 + 'h55);
    chk("R2 w2", wr_a[2] * 256 + wr_d[2], 'h555 * 256 + 'h80);
    chk("R2 w3", wr_a[3] * 256 + wr_d[3], 'h555 * 256 + 'hAA);
    chk("R2 w4", wr_a[4] * 256 + wr_d[4], 'h2AA * 256 + 'h55);
    chk("R2 w5", wr_a[5] * 256 + wr_d[5], sect_of(0) * 256 + 'h30);
    @(negedge clk);
    chk("R8 done low", int'(done), 0);
    chk("R8 busy low", int'(busy), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      pulse_start();
      wait_done(e);
      chk($sformatf("R3 R4 R5 vec%0d err", v), e, VEC[v][4]);
      chk($sformatf("R3 R5 vec%0d writes", v), wr_n, VEC[v][5]);
      chk($sformatf("R5 vec%0d reset writes", v), rst_wr, (VEC[v][3] != 0 && VEC[v][4] != 0) ? 1 : 0);
      if (v == 1) begin
        chk("R3 sect1", wr_a[6] * 256 + wr_d[6], sect_of(1) * 256 + 'h30);
        chk("R3 sect2", wr_a[7] * 256 + wr_d[7], sect_of(2) * 256 + 'h30);
      end
      if (v == 2) begin
        repeat (4) @(negedge clk);
        chk("R8 error held", int'(err), 1);
        chk("R3 no third append", wr_n, 7);
      end
      @(negedge clk);
    end

    // R8 error cleared by next start
    setup(1, 3, 9, 0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R8 error cleared", int'(err), 0);
    wait_done(e);
    @(negedge clk);

    // R6 watchdog
    setup(1, 1000, 2000, 0);
    pulse_start();
    wait_done(e);
    chk("R6 err", e, 1);
    chk("R6 poll reads", rd_total, MAX_POLLS);
    chk("R6 writes", wr_n, 7);
    chk("R6 last write", wr_a[6] * 256 + wr_d[6], 'h555 * 256 + 'hF0);
    @(negedge clk);

    // R7 start while busy
    setup(1, 15, 99, 0);
    pulse_start();
    repeat (30) @(negedge clk);
    chk("R7 busy", int'(busy), 1);
    cnt = CNT_W'(3);
    pulse_start();
    wait_done(e);
    chk("R7 err", e, 0);
    @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R7 no extra done", int'(done), 0);
    chk("R7 writes", wr_n, 6);
    chk("R7 idle", int'(busy), 0);

    // R9 zero count
    setup(0, 3, 9, 0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R9 zero done", int'(done), 1);
    chk("R9 zero err", int'(err), 1);
    repeat (3) @(negedge clk);
    chk("R9 zero no traffic", wr_n + rd_total, 0);

    // R9 clamp
    setup(6, 15, 20, 0);
    pulse_start();
    wait_done(e);
    chk("R9 clamp err", e, 0);
    chk("R9 clamp writes", wr_n, 5 + MAX_SECT);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule